// File: doc/BRIEF.md
# PCI Window Address Translator

This block turns 32-bit addresses that a PCI device drives for a DMA transfer into 34-bit memory addresses. It holds a small set of programmable windows. Each window has three 64-bit registers: a match base, a size mask and a target base. A bus address falls into a window when the two agree on the bits 30:20 that the mask leaves uncovered. The first enabled window in index order that matches does the translation. Its mode bit picks between two schemes. In the direct scheme, the low part of the bus address is placed inside the target region. In the scatter-gather scheme, one 64-bit page-table entry is read from memory and the page number it holds is combined with the 4 KiB page offset.

Translation requests arrive on a valid/ready handshake. Each accepted request gives exactly one response pulse with an address and a hit flag, so a real translation to address 0 can be told apart from a miss. While a table entry is being fetched, the block accepts no new request. Software programs the windows through a simple register port that allows 64-bit accesses only.

Top module: `pci_window_xlate`

## Requirements
- R1: After reset, every window register reads back as zero and `xl_ready` is high.
- R2: A register is selected by `csr_addr >> 6`. Indices 0..3 are the match bases, 4..7 the size masks and 8..11 the target bases. A legal 64-bit write is read back unchanged. `csr_ack` pulses in the cycle after `csr_req`, together with `csr_rdata` and `csr_err`.
- R3: Index 12 (control) and index 13 (invalidate-all) accept writes without error and without effect, and both read as zero.
- R4: An access raises `csr_err` and changes no register in any of these cases: `csr_size` is not 3 (0=8, 1=16, 2=32, 3=64 bits), `csr_addr[5:0]` is not zero, or the index is above 13. Its `csr_rdata` is zero.
- R5: A window matches when bus address and match base agree on every bit in 30:20 where the size mask is 0. All other bits are ignored for matching.
- R6: Bit 0 of the match base enables the window. A window that matches but is disabled is skipped, and the search continues with the next index.
- R7: When several windows qualify, the lowest index wins.
- R8: When no window qualifies, the response has `rsp_hit`=0 and `rsp_addr`=0.
- R9: In direct mode (match base bit 1 = 0), the offset mask is size-mask bits 30:20 plus bits 19:0. The result takes the bus address inside the offset mask and the target base elsewhere, truncated to 34 bits. It is returned in the cycle after acceptance.
- R10: In scatter-gather mode (bit 1 = 1), one read is issued to `mem_rd_addr`. That address is the target base with bits 9:0 cleared and with bits 20:10 cleared where size-mask bits 30:20 are set, ORed with (bus address AND (size-mask bits 30:20 plus bits 19:13)) shifted right by 10. The request holds valid and address until `mem_rd_ready`.
- R11: The scatter-gather result is (entry with bit 0 cleared) shifted left by 12, ORed with bus bits 11:0 and truncated to 34 bits. It is returned, with `rsp_hit`=1, in the cycle after `mem_rsp_valid`.
- R12: From acceptance of a scatter-gather request until its data returns, `xl_ready` is low. Each accepted request produces exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_req | input | 1 | Register access strobe |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_size | input | 2 | Access size code, only 3 (64-bit) is legal |
| csr_addr | input | 10 | Byte offset from the block base |
| csr_wdata | input | 64 | Write data |
| csr_ack | output | 1 | Access completed (one cycle after request) |
| csr_err | output | 1 | Access was illegal |
| csr_rdata | output | 64 | Read data |
| xl_valid | input | 1 | Translation request valid |
| xl_ready | output | 1 | Translator can accept a request |
| xl_bus_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_hit | output | 1 | A window qualified |
| rsp_addr | output | 34 | Translated memory address |
| mem_rd_valid | output | 1 | Page-table entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 64 | Page-table entry address |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Page-table entry |

## Verification
The hardest case to reach from the ports is an address that several windows match at once, where the lower windows are disabled or in a different mode. Random address sampling almost never produces this, because matching depends on the size-mask bits over 30:20. The stimulus therefore builds window sets that share one match base under varied masks and enable patterns, and draws most bus addresses from inside a chosen window's span. The scatter-gather path also gets randomly stretched request-accept and data-return delays, so the bench covers the busy interval and the held request.

// File: rtl/pdx_pkg.sv
package pdx_pkg;

  localparam logic [1:0]  SZ_DWORD   = 2'd3;
  localparam logic [63:0] SPAN_BITS  = 64'h0000_0000_7FF0_0000;
  localparam logic [63:0] LOW_OFFSET = 64'h0000_0000_000F_FFFF;
  localparam logic [63:0] PTE_SLICE  = 64'h0000_0000_000F_E000;
  localparam logic [63:0] PAGE_OFS   = 64'h0000_0000_0000_0FFF;

  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_REQ  = 2'd1,
    WALK_WAIT = 2'd2
  } walk_state_t;

  function automatic logic [63:0] span_of(input logic [63:0] size_mask);
    return size_mask & SPAN_BITS;
  endfunction

  function automatic logic [63:0] cmp_mask(input logic [63:0] size_mask);
    return ~size_mask & SPAN_BITS;
  endfunction

  function automatic logic win_match(input logic [63:0] bus,
                                     input logic [63:0] base,
                                     input logic [63:0] size_mask);
    return ((bus ^ base) & cmp_mask(size_mask)) == 64'd0;
  endfunction

  function automatic logic [63:0] direct_map(input logic [63:0] tgt,
                                             input logic [63:0] size_mask,
                                             input logic [63:0] bus);
    logic [63:0] ofs;
    ofs = span_of(size_mask) | LOW_OFFSET;
    return (tgt & ~ofs) | (bus & ofs);
  endfunction

  function automatic logic [63:0] pte_addr(input logic [63:0] tgt,
                                           input logic [63:0] size_mask,
                                           input logic [63:0] bus);
    logic [63:0] keep;
    logic [63:0] pick;
    keep = ~((span_of(size_mask) >> 10) | 64'h3FF);
    pick = span_of(size_mask) | PTE_SLICE;
    return (tgt & keep) | ((bus & pick) >> 10);
  endfunction

  function automatic logic [63:0] pte_map(input logic [63:0] pte,
                                          input logic [63:0] bus);
    return ((pte & ~64'd1) << 12) | (bus & PAGE_OFS);
  endfunction

endpackage

// File: rtl/pdx_regs.sv
module pdx_regs
  import pdx_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int CSR_AW  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_req,
  input  logic              csr_we,
  input  logic [1:0]        csr_size,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [63:0]       csr_wdata,
  output logic              csr_ack,
  output logic              csr_err,
  output logic [63:0]       csr_rdata,
  output logic [63:0]       win_base [NUM_WIN],
  output logic [63:0]       win_mask [NUM_WIN],
  output logic [63:0]       win_tgt  [NUM_WIN]
);

  localparam int MASK_OFS  = NUM_WIN;
  localparam int TGT_OFS   = 2 * NUM_WIN;
  localparam int CTRL_IDX  = 3 * NUM_WIN;
  localparam int INVAL_IDX = CTRL_IDX + 1;

  logic [31:0] idx;
  logic        aligned;
  logic        size_ok;
  logic        known;
  logic        legal;
  logic        wr_ok;
  logic [63:0] rd_mux;

  logic [63:0] base_q [NUM_WIN];
  logic [63:0] mask_q [NUM_WIN];
  logic [63:0] tgt_q  [NUM_WIN];

  assign idx     = 32'(csr_addr[CSR_AW-1:6]);
  assign aligned = (csr_addr[5:0] == 6'd0);
  assign size_ok = (csr_size == SZ_DWORD);
  assign known   = (idx <= 32'(INVAL_IDX));
  assign legal   = aligned && size_ok && known;
  assign wr_ok   = csr_req && csr_we && legal;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_WIN; gi++) begin : g_win
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          base_q[gi] <= '0;
          mask_q[gi] <= '0;
          tgt_q[gi]  <= '0;
        end else if (wr_ok) begin
          if (idx == 32'(gi))            base_q[gi] <= csr_wdata;
          if (idx == 32'(MASK_OFS + gi)) mask_q[gi] <= csr_wdata;
          if (idx == 32'(TGT_OFS + gi))  tgt_q[gi]  <= csr_wdata;
        end
      end
      assign win_base[gi] = base_q[gi];
      assign win_mask[gi] = mask_q[gi];
      assign win_tgt[gi]  = tgt_q[gi];
    end
  endgenerate

  // control and invalidate-all indices fall through to zero
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (idx == 32'(i))            rd_mux = base_q[i];
      if (idx == 32'(MASK_OFS + i)) rd_mux = mask_q[i];
      if (idx == 32'(TGT_OFS + i))  rd_mux = tgt_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_ack   <= 1'b0;
      csr_err   <= 1'b0;
      csr_rdata <= '0;
    end else begin
      csr_ack   <= csr_req;
      csr_err   <= csr_req && !legal;
      csr_rdata <= (csr_req && legal && !csr_we) ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/pdx_window_sel.sv
module pdx_window_sel
  import pdx_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int BUS_AW  = 32,
  parameter int DMA_AW  = 34
) (
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [63:0]       win_base [NUM_WIN],
  input  logic [63:0]       win_mask [NUM_WIN],
  input  logic [63:0]       win_tgt  [NUM_WIN],
  output logic              sel_hit,
  output logic              sel_sg,
  output logic [DMA_AW-1:0] sel_direct,
  output logic [63:0]       sel_entry
);

  localparam int IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [63:0]        bus64;
  logic [NUM_WIN-1:0] qual;
  logic [IW-1:0]      pick;

  assign bus64 = 64'(bus_addr);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_WIN; gi++) begin : g_cmp
      assign qual[gi] = win_match(bus64, win_base[gi], win_mask[gi]) && win_base[gi][0];
    end
  endgenerate

  always_comb begin
    sel_hit = 1'b0;
    pick    = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (qual[i] && !sel_hit) begin
        sel_hit = 1'b1;
        pick    = IW'(i);
      end
    end
  end

  assign sel_sg     = win_base[pick][1];
  assign sel_direct = DMA_AW'(direct_map(win_tgt[pick], win_mask[pick], bus64));
  assign sel_entry  = pte_addr(win_tgt[pick], win_mask[pick], bus64);

endmodule

// File: rtl/pdx_walk.sv
module pdx_walk
  import pdx_pkg::*;
#(
  parameter int BUS_AW = 32,
  parameter int DMA_AW = 34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_ev,
  input  logic [BUS_AW-1:0] xl_bus_addr,
  output logic              xl_ready,
  input  logic              sel_hit,
  input  logic              sel_sg,
  input  logic [DMA_AW-1:0] sel_direct,
  input  logic [63:0]       sel_entry,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [63:0]       mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              fetch_done_ev,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DMA_AW-1:0] rsp_addr
);

  walk_state_t       state;
  logic [BUS_AW-1:0] bus_q;
  logic [63:0]       ent_q;
  logic              start_walk;

  assign xl_ready      = (state == WALK_IDLE);
  assign mem_rd_valid  = (state == WALK_REQ);
  assign mem_rd_addr   = ent_q;
  assign fetch_done_ev = (state == WALK_WAIT) && mem_rsp_valid;
  assign start_walk    = accept_ev && sel_hit && sel_sg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= WALK_IDLE;
      bus_q     <= '0;
      ent_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        WALK_IDLE: begin
          if (start_walk) begin
            state <= WALK_REQ;
            bus_q <= xl_bus_addr;
            ent_q <= sel_entry;
          end else if (accept_ev) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= sel_hit;
            rsp_addr  <= sel_hit ? sel_direct : '0;
          end
        end
        WALK_REQ: begin
          if (mem_rd_ready) state <= WALK_WAIT;
        end
        WALK_WAIT: begin
          if (fetch_done_ev) begin
            state     <= WALK_IDLE;
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_addr  <= DMA_AW'(pte_map(mem_rsp_data, 64'(bus_q)));
          end
        end
        default: state <= WALK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pci_window_xlate.sv
module pci_window_xlate
  import pdx_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int BUS_AW  = 32,
  parameter int DMA_AW  = 34,
  parameter int CSR_AW  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_req,
  input  logic              csr_we,
  input  logic [1:0]        csr_size,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [63:0]       csr_wdata,
  output logic              csr_ack,
  output logic              csr_err,
  output logic [63:0]       csr_rdata,
  input  logic              xl_valid,
  output logic              xl_ready,
  input  logic [BUS_AW-1:0] xl_bus_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DMA_AW-1:0] rsp_addr,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [63:0]       mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data
);

  logic [63:0]       win_base [NUM_WIN];
  logic [63:0]       win_mask [NUM_WIN];
  logic [63:0]       win_tgt  [NUM_WIN];
  logic              sel_hit;
  logic              sel_sg;
  logic [DMA_AW-1:0] sel_direct;
  logic [63:0]       sel_entry;
  logic              accept_ev;
  logic              fetch_done_ev;

  assign accept_ev = xl_valid && xl_ready;

  pdx_regs #(.NUM_WIN(NUM_WIN), .CSR_AW(CSR_AW)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_req   (csr_req),
    .csr_we    (csr_we),
    .csr_size  (csr_size),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_ack   (csr_ack),
    .csr_err   (csr_err),
    .csr_rdata (csr_rdata),
    .win_base  (win_base),
    .win_mask  (win_mask),
    .win_tgt   (win_tgt)
  );

  pdx_window_sel #(.NUM_WIN(NUM_WIN), .BUS_AW(BUS_AW), .DMA_AW(DMA_AW)) sel_i (
    .bus_addr   (xl_bus_addr),
    .win_base   (win_base),
    .win_mask   (win_mask),
    .win_tgt    (win_tgt),
    .sel_hit    (sel_hit),
    .sel_sg     (sel_sg),
    .sel_direct (sel_direct),
    .sel_entry  (sel_entry)
  );

  pdx_walk #(.BUS_AW(BUS_AW), .DMA_AW(DMA_AW)) walk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept_ev     (accept_ev),
    .xl_bus_addr   (xl_bus_addr),
    .xl_ready      (xl_ready),
    .sel_hit       (sel_hit),
    .sel_sg        (sel_sg),
    .sel_direct    (sel_direct),
    .sel_entry     (sel_entry),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .fetch_done_ev (fetch_done_ev),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_addr      (rsp_addr)
  );

endmodule

// File: rtl/pci_window_xlate_chk.sv
module pci_window_xlate_chk #(
  parameter int DMA_AW = 34
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_req,
  input logic [1:0]        csr_size,
  input logic              csr_ack,
  input logic              csr_err,
  input logic              xl_ready,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic [63:0]       mem_rd_addr,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [DMA_AW-1:0] rsp_addr,
  input logic              accept_ev,
  input logic              fetch_done_ev
);

  p_ack_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_req |=> csr_ack);

  p_ack_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_ack |-> $past(csr_req));

  p_bad_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_size != 2'd3) |=> csr_err);

  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == '0));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !xl_ready);

  p_rsp_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(accept_ev) || $past(fetch_done_ev)));

  p_walk_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done_ev |=> (rsp_valid && rsp_hit));

endmodule

bind pci_window_xlate pci_window_xlate_chk #(.DMA_AW(DMA_AW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .csr_req       (csr_req),
  .csr_size      (csr_size),
  .csr_ack       (csr_ack),
  .csr_err       (csr_err),
  .xl_ready      (xl_ready),
  .mem_rd_valid  (mem_rd_valid),
  .mem_rd_ready  (mem_rd_ready),
  .mem_rd_addr   (mem_rd_addr),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .rsp_addr      (rsp_addr),
  .accept_ev     (accept_ev),
  .fetch_done_ev (fetch_done_ev)
);

// File: tb/pci_window_xlate_tb_top.sv
`timescale 1ns/1ps
module pci_window_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_req = 1'b0, csr_we = 1'b0;
  logic [1:0]  csr_size = 2'd3;
  logic [9:0]  csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic        csr_ack, csr_err;
  logic [63:0] csr_rdata;
  logic        xl_valid = 1'b0;
  logic        xl_ready;
  logic [31:0] xl_bus_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [33:0] rsp_addr;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [63:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  int total = 0;
  int bad = 0;

  logic [63:0] m_base [4];
  logic [63:0] m_mask [4];
  logic [63:0] m_tgt  [4];

  always #4 clk = ~clk;

  pci_window_xlate dut_i (.*);

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pte_of(input logic [63:0] a);
    return (a * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0000_1234_5678_9ABD;
  endfunction

  // expected result restated bit-field by bit-field
  task automatic model(input logic [31:0] a, output logic hit, output logic sg,
                       output logic [63:0] ent, output logic [33:0] res);
    hit = 1'b0; sg = 1'b0; ent = '0; res = '0;
    for (int w = 0; w < 4; w++) begin
      if (!hit && m_base[w][0] &&
          (((a[30:20] ^ m_base[w][30:20]) & ~m_mask[w][30:20]) == 11'd0)) begin
        logic [63:0] t;
        hit = 1'b1;
        sg  = m_base[w][1];
        t = m_tgt[w];
        t[19:0] = a[19:0];
        for (int b = 20; b <= 30; b++) if (m_mask[w][b]) t[b] = a[b];
        res = t[33:0];
        ent = m_tgt[w];
        ent[9:0] = '0;
        for (int b = 10; b <= 20; b++) if (m_mask[w][b+10]) begin
          ent[b] = a[b+10];
        end
        ent[9:3] = a[19:13];
      end
    end
  endtask

  task automatic csr_op(input logic we, input logic [9:0] addr, input logic [1:0] sz,
                        input logic [63:0] wd, output logic [63:0] rd, output logic err);
    @(negedge clk);
    csr_req = 1'b1; csr_we = we; csr_addr = addr; csr_size = sz; csr_wdata = wd;
    @(negedge clk);
    csr_req = 1'b0; csr_we = 1'b0;
    chk(csr_ack === 1'b1, "R2 ack", 64'(csr_ack), 64'd1);
    rd = csr_rdata; err = csr_err;
  endtask

  task automatic wr_reg(input int idx, input logic [63:0] v);
    logic [63:0] rd; logic err;
    csr_op(1'b1, 10'(idx << 6), 2'd3, v, rd, err);
    if (idx < 4) m_base[idx] = v;
    else if (idx < 8) m_mask[idx-4] = v;
    else if (idx < 12) m_tgt[idx-8] = v;
  endtask

  task automatic do_xlate(input logic [31:0] a);
    logic hit, sg; logic [63:0] ent, pte; logic [33:0] res;
    model(a, hit, sg, ent, res);
    @(negedge clk);
    chk(xl_ready === 1'b1, "R12 ready idle", 64'(xl_ready), 64'd1);
    xl_valid = 1'b1; xl_bus_addr = a;
    @(negedge clk);
    xl_valid = 1'b0;
    if (hit && sg) begin
      chk(mem_rd_valid === 1'b1 && mem_rd_addr === ent, "R10 entry addr", mem_rd_addr, ent);
      chk(xl_ready === 1'b0, "R12 busy", 64'(xl_ready), 64'd0);
      repeat ($urandom_range(0, 2)) begin
        @(negedge clk);
        chk(mem_rd_valid === 1'b1 && mem_rd_addr === ent, "R10 hold", mem_rd_addr, ent);
      end
      mem_rd_ready = 1'b1;
      @(negedge clk);
      mem_rd_ready = 1'b0;
      repeat ($urandom_range(0, 2)) begin
        @(negedge clk);
        chk(rsp_valid === 1'b0 && xl_ready === 1'b0, "R12 wait", 64'(rsp_valid), 64'd0);
      end
      pte = pte_of(ent);
      mem_rsp_valid = 1'b1; mem_rsp_data = pte;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      res = {pte[21:1], 1'b0, a[11:0]};
      chk(rsp_valid === 1'b1 && rsp_hit === 1'b1 && rsp_addr === res,
          "R11 sg result", 64'(rsp_addr), 64'(res));
    end else if (hit) begin
      chk(rsp_valid === 1'b1 && rsp_hit === 1'b1 && rsp_addr === res,
          "R9 direct result", 64'(rsp_addr), 64'(res));
    end else begin
      chk(rsp_valid === 1'b1 && rsp_hit === 1'b0 && rsp_addr === 34'd0,
          "R8 miss", 64'(rsp_addr), 64'd0);
    end
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R12 single response", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] rd; logic err;
    void'($urandom(32'd20250917));
    for (int w = 0; w < 4; w++) begin m_base[w] = '0; m_mask[w] = '0; m_tgt[w] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(xl_ready === 1'b1, "R1 ready", 64'(xl_ready), 64'd1);
    for (int i = 0; i < 12; i++) begin
      csr_op(1'b0, 10'(i << 6), 2'd3, '0, rd, err);
      chk(rd === 64'd0 && !err, "R1 reset value", rd, 64'd0);
    end

    // R2 readback
    for (int i = 0; i < 12; i++) wr_reg(i, {$urandom, $urandom});
    for (int i = 0; i < 12; i++) begin
      logic [63:0] e;
      e = (i < 4) ? m_base[i] : (i < 8) ? m_mask[i-4] : m_tgt[i-8];
      csr_op(1'b0, 10'(i << 6), 2'd3, '0, rd, err);
      chk(rd === e && !err, "R2 readback", rd, e);
    end

    // R3 control and invalidate
    for (int i = 12; i < 14; i++) begin
      csr_op(1'b1, 10'(i << 6), 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, rd, err);
      chk(!err, "R3 write no error", 64'(err), 64'd0);
      csr_op(1'b0, 10'(i << 6), 2'd3, '0, rd, err);
      chk(rd === 64'd0 && !err, "R3 reads zero", rd, 64'd0);
    end
    csr_op(1'b0, 10'(0), 2'd3, '0, rd, err);
    chk(rd === m_base[0], "R3 no side effect", rd, m_base[0]);

    // R4 errors
    for (int s = 0; s < 3; s++) begin
      csr_op(1'b1, 10'(0), 2'(s), 64'hDEAD, rd, err);
      chk(err === 1'b1, "R4 size error", 64'(err), 64'd1);
    end
    csr_op(1'b1, 10'(8), 2'd3, 64'hBEEF, rd, err);
    chk(err === 1'b1, "R4 misaligned error", 64'(err), 64'd1);
    csr_op(1'b1, 10'(14 << 6), 2'd3, 64'h1, rd, err);
    chk(err === 1'b1, "R4 unknown index", 64'(err), 64'd1);
    csr_op(1'b0, 10'(15 << 6), 2'd3, '0, rd, err);
    chk(err === 1'b1 && rd === 64'd0, "R4 unknown read zero", rd, 64'd0);
    csr_op(1'b0, 10'(0), 2'd2, '0, rd, err);
    chk(rd === 64'd0, "R4 error rdata zero", rd, 64'd0);
    csr_op(1'b0, 10'(0), 2'd3, '0, rd, err);
    chk(rd === m_base[0], "R4 write ignored", rd, m_base[0]);

    // directed: R6 disabled window 0 overlaps enabled window 1; R7 priority
    wr_reg(0, 64'h0000_0000_4000_0000);           // disabled, direct
    wr_reg(4, 64'h0000_0000_0FF0_0000);
    wr_reg(8, 64'h0000_0000_1111_1111);
    wr_reg(1, 64'h0000_0000_4000_0001);           // enabled direct
    wr_reg(5, 64'h0000_0000_0FF0_0000);
    wr_reg(9, 64'hFFFF_FFF3_8000_0000);           // R9 truncation of high bits
    wr_reg(2, 64'h0000_0000_4000_0003);           // enabled sg, also matches
    wr_reg(6, 64'h0000_0000_0FF0_0000);
    wr_reg(10, 64'h0000_0000_0012_3000);
    wr_reg(3, 64'h0000_0000_0000_0003);           // sg at 0x0
    wr_reg(7, 64'h0000_0000_0010_0000);
    wr_reg(11, 64'h0000_0001_0000_0000);
    do_xlate(32'h4ABC_DEF0);                      // R6 R7 -> window 1 direct
    do_xlate(32'h0005_4321);                      // R10 R11 window 3 sg
    do_xlate(32'h0015_4321);                      // R5 mask bit 20 set
    do_xlate(32'h2000_0000);                      // R8 miss
    do_xlate(32'hC000_1234);                      // R5 bit 31 ignored -> window 1
    wr_reg(1, 64'h0000_0000_4000_0000);           // disable 1 -> window 2 sg
    do_xlate(32'h4ABC_DEF0);

    // random rounds
    for (int r = 0; r < 6; r++) begin
      logic [63:0] shared;
      shared = {$urandom, $urandom};
      for (int w = 0; w < 4; w++) begin
        logic [63:0] b;
        b = (r % 2 == 0) ? shared : {$urandom, $urandom};
        b[1:0] = 2'($urandom);
        wr_reg(w, b);
        wr_reg(4 + w, {$urandom, $urandom});
        wr_reg(8 + w, {$urandom, $urandom});
      end
      for (int n = 0; n < 60; n++) begin
        logic [31:0] a;
        int w;
        w = $urandom_range(0, 3);
        if ($urandom_range(0, 9) < 7)
          a = m_base[w][31:0] ^ ($urandom & {1'b1, m_mask[w][30:20], 20'hFFFFF});
        else
          a = $urandom;
        do_xlate(a);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule